// File: doc/BRIEF.md
# Temporal-Spatial FRC Dither Unit

This block narrows 24-bit RGB video (three 8-bit subpixels) to 18-bit colour for a 6-bit-per-colour panel. The two bits dropped from each subpixel are not thrown away. They are compared against a threshold that depends on the pixel's position within a 2x2 tile and on a 2-bit frame counter. When the remainder beats the threshold, the kept 6-bit value is bumped up by one. Averaged over a tile and over four frames, the light output then lands on the missing intermediate levels.

The unit sits in a pixel pipeline with one register stage. A chip can place two copies, one ahead of a colour lookup stage and one after it, and each copy is switched on by its own enable bit. A frame-start strobe and a line-start strobe from the timing logic keep the tile position aligned with the picture. When the unit is switched off, it forwards the pixel unchanged with the same one-cycle delay.

Top module: `frc_dither`

## Requirements
- R1: `pix_valid_o` is `pix_valid` delayed by exactly one clock, and `pix_o` updates on that same clock edge, whether the unit is enabled or not.
- R2: Channel packing is red in bits 23:16, green in bits 15:8 and blue in bits 7:0. When enabled, each output channel's bits [7:2] equal the input's bits [7:2] plus a bump of 0 or 1.
- R3: The bump is 1 when the input's bits [1:0] are greater than the threshold idx = (2*row_parity + col_parity + frame_count) mod 4.
- R4: `frame_count` is 2 bits wide, resets to 0, and advances by one on each `frame_start`. The advanced value already applies to a pixel presented in the same cycle as `frame_start`.
- R5: The bump never carries past 63. An input whose bits [7:2] are all ones keeps them all ones.
- R6: When `en` is 0, the output channel equals the input channel, all 8 bits, with no dithering.
- R7: When `en` is 1, bits [1:0] of every output channel are 0.
- R8: `col_parity` is 0 for a pixel presented with `line_start` or `frame_start`, and otherwise toggles after each valid pixel only. `row_parity` is 0 from `frame_start` and toggles on each `line_start`.
- R9: After reset, `pix_valid_o` is 0 and `pix_o` is 0.
- R10: Over four successive frames, a pixel at a fixed position is bumped as many times as the value of its input bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Dither enable, sampled with each pixel |
| pix_valid | input | 1 | Input pixel qualifier |
| line_start | input | 1 | Start of a new line (may coincide with a pixel) |
| frame_start | input | 1 | Start of a new frame, which is also line 0 |
| pix_i | input | 24 | Input pixel {R,G,B}, 8 bits each |
| pix_valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 24 | Output pixel {R,G,B}; low 2 bits of each channel are 0 when enabled |

## Verification
The bench drives remainders of 1, 2 and 3 through full 2x2 tiles across four frames. A design with a wrong threshold order, or a frame counter that takes effect one pixel late, shows mismatches at specific tile corners, and its four-frame bump totals drift from the remainder values. All-ones channels check saturation: a wrapping adder would turn 0xFF into 0x00. Gaps with `pix_valid` low between pixels, and line starts with no pixel, check that a column counter advancing on every cycle would shift the pattern. Disabled pixels must come out bit-exact with the same delay, which catches a unit that still truncates or adds a stage when switched off.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned KEEP_W = 6;
  localparam int unsigned NCH    = 3;
  localparam int unsigned DROP_W = CH_W - KEEP_W;

  typedef logic [DROP_W-1:0] thr_t;
endpackage

// File: rtl/frc_pos.sv
module frc_pos
  import frc_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic pix_valid,
  input  logic line_start,
  input  logic frame_start,
  output thr_t thr
);
  logic row_q, row_d, col_q, col_d;
  thr_t fcnt_q, fcnt_d;
  logic row_eff, col_eff;
  thr_t fcnt_eff;

  // Position seen by the pixel in this cycle
  always_comb begin
    fcnt_eff = frame_start ? thr_t'(fcnt_q + thr_t'(1)) : fcnt_q;
    if (frame_start)     row_eff = 1'b0;
    else if (line_start) row_eff = ~row_q;
    else                 row_eff = row_q;
    col_eff = (line_start || frame_start) ? 1'b0 : col_q;
    thr     = thr_t'({row_eff, 1'b0}) + thr_t'(col_eff) + fcnt_eff;
  end

  // Next state
  always_comb begin
    row_d  = row_eff;
    fcnt_d = fcnt_eff;
    col_d  = pix_valid ? ~col_eff : col_eff;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      row_q  <= 1'b0;
      col_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      fcnt_q <= fcnt_d;
    end
  end

  AST_COL_RESTART: assert property (@(posedge clk) disable iff (!rst_sn)
    (pix_valid && (line_start || frame_start)) |=> col_q) else $error("col parity"); // R8
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (!pix_valid && !line_start && !frame_start) |=> $stable(col_q)) else $error("col hold"); // R8
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_start |=> (fcnt_q == thr_t'($past(fcnt_q) + thr_t'(1)))) else $error("frame step"); // R4
endmodule

// File: rtl/frc_chan.sv
module frc_chan
  import frc_pkg::*;
(
  input  logic            en,
  input  thr_t            thr,
  input  logic [CH_W-1:0] din,
  output logic [CH_W-1:0] dout
);
  localparam logic [KEEP_W-1:0] TOP_MAX = '1;

  logic [KEEP_W-1:0] top;
  logic [DROP_W-1:0] rem;
  logic              bump;

  always_comb begin
    top  = din[CH_W-1:DROP_W];
    rem  = din[DROP_W-1:0];
    bump = (rem > thr) && (top != TOP_MAX);
    if (en) dout = {top + KEEP_W'(bump), {DROP_W{1'b0}}};
    else    dout = din;
  end

  always_comb begin
    if (en === 1'b1 && top === TOP_MAX)
      AST_NO_OVERFLOW: assert (dout[CH_W-1:DROP_W] == TOP_MAX) else $error("wrap"); // R5
    if (en === 1'b1 && rem === '0)
      AST_ZERO_REM: assert (dout[CH_W-1:DROP_W] == top) else $error("bump on zero"); // R3
  end
endmodule

// File: rtl/frc_dither.sv
module frc_dither
  import frc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                pix_valid,
  input  logic                line_start,
  input  logic                frame_start,
  input  logic [NCH*CH_W-1:0] pix_i,
  output logic                pix_valid_o,
  output logic [NCH*CH_W-1:0] pix_o
);
  localparam int unsigned PIX_W = NCH * CH_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  thr_t             thr;
  logic [PIX_W-1:0] dith;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             vld_q, vld_d;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  frc_pos u_pos (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .pix_valid   (pix_valid),
    .line_start  (line_start),
    .frame_start (frame_start),
    .thr         (thr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    frc_chan u_chan (
      .en   (en),
      .thr  (thr),
      .din  (pix_i[c*CH_W +: CH_W]),
      .dout (dith[c*CH_W +: CH_W])
    );
  end

  always_comb begin
    vld_d = pix_valid;
    pix_d = pix_valid ? dith : pix_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q <= 1'b0;
      pix_q <= '0;
    end else begin
      vld_q <= vld_d;
      pix_q <= pix_d;
    end
  end

  assign pix_valid_o = vld_q;
  assign pix_o       = pix_q;

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_sn)
    pix_valid |=> pix_valid_o) else $error("valid lat"); // R1
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_sn)
    !pix_valid |=> !pix_valid_o) else $error("idle lat"); // R1
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_sn)
    (pix_valid && !en) |=> (pix_o == $past(pix_i))) else $error("bypass"); // R6
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (pix_valid && en) |=> (pix_o[1:0] == 2'b00 && pix_o[9:8] == 2'b00 && pix_o[17:16] == 2'b00))
    else $error("low bits"); // R7
endmodule

// File: tb/frc_dither_tb_top.sv
module frc_dither_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, en, pix_valid, line_start, frame_start;
  logic [23:0] pix_i;
  logic        pix_valid_o;
  logic [23:0] pix_o;

  int checks = 0;
  int errors = 0;
  logic       m_row, m_col;
  logic [1:0] m_fc;

  always #10 clk = ~clk;

  frc_dither dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pix_valid(pix_valid),
    .line_start(line_start), .frame_start(frame_start), .pix_i(pix_i),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ch(input logic [7:0] d, input logic [1:0] idx, input logic e);
    logic [5:0] t;
    logic       b;
    t = d[7:2];
    b = (d[1:0] > idx) && (t != 6'h3F);
    return e ? {t + {5'd0, b}, 2'b00} : d;
  endfunction

  // Advance the bench's position model; returns threshold for this cycle
  function automatic logic [1:0] model_step(input logic v, input logic ls, input logic fs);
    logic r, c;
    logic [1:0] f;
    f = fs ? m_fc + 2'd1 : m_fc;
    r = fs ? 1'b0 : (ls ? ~m_row : m_row);
    c = (ls || fs) ? 1'b0 : m_col;
    m_fc = f; m_row = r; m_col = v ? ~c : c;
    return {r, 1'b0} + {1'b0, c} + f;
  endfunction

  task automatic send(input logic [23:0] p, input logic ls, input logic fs, input string req);
    logic [1:0]  idx;
    logic [23:0] e;
    @(negedge clk);
    pix_i = p; pix_valid = 1'b1; line_start = ls; frame_start = fs;
    idx = model_step(1'b1, ls, fs);
    e = {exp_ch(p[23:16], idx, en), exp_ch(p[15:8], idx, en), exp_ch(p[7:0], idx, en)};
    @(negedge clk);
    pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0;
    check({req, " R1 valid"}, {31'd0, pix_valid_o}, 32'd1);
    check(req, {8'd0, pix_o}, {8'd0, e});
  endtask

  task automatic strobe(input logic ls, input logic fs);
    logic [1:0] unused_idx;
    @(negedge clk);
    pix_valid = 1'b0; line_start = ls; frame_start = fs;
    unused_idx = model_step(1'b0, ls, fs);
    @(negedge clk);
    line_start = 1'b0; frame_start = 1'b0;
    check("R1 idle", {31'd0, pix_valid_o}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; pix_valid = 1'b0; line_start = 1'b0; frame_start = 1'b0; pix_i = '0;
    m_row = 1'b0; m_col = 1'b0; m_fc = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 valid", {31'd0, pix_valid_o}, 32'd0);
    check("R9 data", {8'd0, pix_o}, 32'd0);
  endtask

  task automatic t_bypass;
    en = 1'b0;
    send(24'hA73EF1, 1'b0, 1'b1, "R6 bypass");
    send(24'hFFFFFF, 1'b0, 1'b0, "R6 bypass ones");
    send(24'h010203, 1'b1, 1'b0, "R6 bypass low");
  endtask

  task automatic t_tiles;
    logic [7:0] sr, sg, sb;
    sr = 0; sg = 0; sb = 0;
    en = 1'b1;
    for (int f = 0; f < 4; f++) begin
      send(24'h4182C7, 1'b0, 1'b1, "R2 R3 R4 R7 tile");
      sr += {2'd0, pix_o[23:18]} - 8'h10;
      sg += {2'd0, pix_o[15:10]} - 8'h20;
      sb += {2'd0, pix_o[7:2]}   - 8'h31;
      send(24'h4182C7, 1'b0, 1'b0, "R3 col1");
      send(24'h4182C7, 1'b1, 1'b0, "R8 row1 col0");
      send(24'h4182C7, 1'b0, 1'b0, "R3 row1 col1");
    end
    check("R10 red sum", {24'd0, sr}, 32'd1);
    check("R10 green sum", {24'd0, sg}, 32'd2);
    check("R10 blue sum", {24'd0, sb}, 32'd3);
  endtask

  task automatic t_saturate;
    en = 1'b1;
    for (int i = 0; i < 4; i++) send(24'hFFFFFF, 1'b0, i == 0, "R5 saturate");
    send(24'hFDFEFF, 1'b0, 1'b0, "R5 mixed top");
  endtask

  task automatic t_gaps;
    en = 1'b1;
    strobe(1'b0, 1'b1);
    send(24'h030303, 1'b0, 1'b0, "R8 after idle frame start");
    strobe(1'b0, 1'b0);
    strobe(1'b0, 1'b0);
    send(24'h030303, 1'b0, 1'b0, "R8 col held over gap");
    strobe(1'b1, 1'b0);
    send(24'h020202, 1'b0, 1'b0, "R8 line start no pixel");
    send(24'h010101, 1'b0, 1'b0, "R8 next col");
    en = 1'b0;
    send(24'h123456, 1'b0, 1'b0, "R6 R1 off mid-line");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_bypass();
        t_tiles();
        t_saturate();
        t_gaps();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule